// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is a small timer peripheral for a CPU subsystem. A 16-bit prescaler runs freely on the system clock, which is nominally 4.194304 MHz. Its upper byte is visible to software as a coarse tick register. An 8-bit up-counter advances at one of four rates, and each rate is taken from one bit of that prescaler. When the counter wraps past 0xFF it reloads from a software-set modulo value and raises a one-cycle interrupt request.

Software sees four byte-wide registers behind a 2-bit address. Writes are single-cycle strobes. Reads are combinational from the current address. A periodic interrupt comes from programming the modulo, selecting a rate and setting the enable bit. The reload period is (256 - modulo) ticks of the chosen rate.

Top module: `prog_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Address 0 reads the prescaler byte, 1 the counter, 2 the modulo and 3 the control register. The control register reads its low three bits, with bits 7:3 as 0. Counter and modulo read back the last value written.
- R3: Address 0 returns bits 15:8 of a 16-bit prescaler that increments every clock, so the byte steps once per 256 clocks. A write of any data to address 0 clears all 16 bits.
- R4: Control bits 1:0 select the counting rate: 00 divides the clock by 1024, 01 by 16, 10 by 64 and 11 by 256. These use prescaler bits 9, 3, 5 and 7. With P the chosen division, after a prescaler clear at edge E the counter steps at edges E+P/2+1+kP.
- R5: Control bit 2 is the enable: 1 lets the counter step, 0 holds it.
- R6: A step from 0xFF loads the counter with the modulo value instead of 0x00.
- R7: `irq_o` is high for exactly the one cycle that follows the edge performing the reload, and at no other time.
- R8: A CPU write to the counter on the same edge as a step wins. The counter takes the written data, and if it held 0xFF no reload or interrupt occurs.
- R9: Writing the modulo register leaves the counter value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address: 0 prescaler, 1 counter, 2 modulo, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | One-cycle interrupt request on reload |

## Verification
All four rate codes are run from a freshly cleared prescaler. The counter is sampled one cycle before and one cycle on each side of the predicted step edges, which separates a wrong tap bit from an off-by-one in the edge detector. Overflow is driven from 0xFE with a non-zero modulo, so a reload to the modulo value is distinguishable from a plain wrap to zero, and the interrupt is checked on the cycles before, during and after the reload. Counter writes are placed exactly on a step edge, both mid-range and at 0xFF, to show whether the write, the increment or the reload wins. A disabled run of a hundred cycles shows that the enable gates counting.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_CNT = 2'd1,
    REG_MOD = 2'd2,
    REG_CTL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_EN_BIT = 2;
  localparam int unsigned RATE_W     = 2;
  localparam int unsigned NUM_RATES  = 1 << RATE_W;
endpackage

// File: rtl/timer_divider.sv
module timer_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [DIV_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_o <= '0;
    else if (clr_i) div_o <= '0;
    else            div_o <= div_o + 1'b1;
  end
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import timer_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned TAP_R0 = 9,
  parameter int unsigned TAP_R1 = 3,
  parameter int unsigned TAP_R2 = 5,
  parameter int unsigned TAP_R3 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [RATE_W-1:0] sel_i,
  input  logic              en_i,
  output logic              tick_o
);
  localparam int unsigned TAP_IDX [NUM_RATES] = '{TAP_R0, TAP_R1, TAP_R2, TAP_R3};

  logic [NUM_RATES-1:0] taps;
  logic                 tap_now;
  logic                 tap_q;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    assign taps[g] = div_i[TAP_IDX[g]];
  end

  assign tap_now = taps[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_now;
  end

  // step on rising edge of the selected prescaler bit
  assign tick_o = en_i & tap_now & ~tap_q;
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mod_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);
  logic at_top;
  assign at_top = (cnt_o == {DATA_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else if (wr_i) begin
      cnt_o <= wdata_i;
      irq_o <= 1'b0;
    end else if (tick_i) begin
      cnt_o <= at_top ? mod_i : cnt_o + 1'b1;
      irq_o <= at_top;
    end else begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] mod_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              tick;
  logic              div_clr;
  logic              cnt_wr;

  assign div_clr = we_i && (addr_i == REG_DIV);
  assign cnt_wr  = we_i && (addr_i == REG_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '0;
      ctl_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_MOD) mod_q <= wdata_i;
      if (addr_i == REG_CTL) ctl_q <= wdata_i[CTL_W-1:0];
    end
  end

  timer_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .div_o  (div_q)
  );

  timer_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .sel_i  (ctl_q[RATE_W-1:0]),
    .en_i   (ctl_q[CTL_EN_BIT]),
    .tick_o (tick)
  );

  timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .mod_i   (mod_q),
    .cnt_o   (cnt_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      REG_DIV: rdata_o = div_q[DIV_W-1 -: DATA_W];
      REG_CNT: rdata_o = cnt_q;
      REG_MOD: rdata_o = mod_q;
      default: rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [DIV_W-1:0]  div_q,
  input logic [2:0]        ctl_q,
  input logic              tick,
  input logic              cnt_wr,
  input logic              div_clr
);
  assert_reload_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt_q == $past(mod_q)));

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_hold_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[2] && !cnt_wr) |=> $stable(cnt_q));

  assert_no_step_without_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !cnt_wr) |=> ($stable(cnt_q) && !irq_o));

  assert_div_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clr |=> (div_q == '0));

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> ((cnt_q == $past(wdata_i)) && !irq_o));
endmodule

bind prog_timer prog_timer_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .mod_q   (mod_q),
  .div_q   (div_q),
  .ctl_q   (ctl_q),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .div_clr (div_clr)
);

// File: tb/prog_timer_tb_top.sv
module prog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_wr = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prog_timer dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    last_wr = cyc;
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reset value", v, 0);
    end
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_readback;
    int v;
    wr(2'd3, 8'hF8);
    rd(2'd3, v); check("R2 control readback masked", v, 8'h00);
    wr(2'd3, 8'hFB);
    rd(2'd3, v); check("R2 control readback", v, 8'h03);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h9A);
    rd(2'd1, v); check("R2 counter readback", v, 8'h9A);
    wr(2'd2, 8'hC3);
    rd(2'd2, v); check("R2 modulo readback", v, 8'hC3);
    rd(2'd1, v); check("R9 counter kept after modulo write", v, 8'h9A);
  endtask

  task automatic t_divider;
    int v, e0;
    wr(2'd0, 8'hA5); e0 = last_wr;
    rd(2'd0, v); check("R3 divider cleared by write", v, 0);
    wait_to(e0 + 255); rd(2'd0, v); check("R3 divider before step", v, 0);
    wait_to(e0 + 256); rd(2'd0, v); check("R3 divider first step", v, 1);
    wait_to(e0 + 512); rd(2'd0, v); check("R3 divider second step", v, 2);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R3 divider cleared again", v, 0);
  endtask

  task automatic t_rate(input logic [1:0] code, input int p);
    int v, e0, h;
    h = p / 2;
    wr(2'd3, {6'd0, code});
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00); e0 = last_wr;
    wr(2'd3, {5'd0, 1'b1, code});
    wait_to(e0 + h);         rd(2'd1, v); check($sformatf("R4 rate %0d before first", code), v, 0);
    wait_to(e0 + h + 1);     rd(2'd1, v); check($sformatf("R4 rate %0d first step", code), v, 1);
    wait_to(e0 + h + p);     rd(2'd1, v); check($sformatf("R4 rate %0d before second", code), v, 1);
    wait_to(e0 + h + p + 1); rd(2'd1, v); check($sformatf("R4 rate %0d second step", code), v, 2);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_disable;
    int v, e0;
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h33); e0 = last_wr;
    wait_to(e0 + 100);
    rd(2'd1, v); check("R5 disabled counter holds", v, 8'h33);
    check("R5 no irq while disabled", irq, 0);
  endtask

  task automatic t_overflow;
    int v, e0;
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h00); e0 = last_wr;
    wr(2'd3, 8'h05);
    wait_to(e0 + 9);  rd(2'd1, v); check("R6 step to FF", v, 8'hFF);
    wait_to(e0 + 24); check("R7 irq low before reload", irq, 0);
    wait_to(e0 + 25); rd(2'd1, v); check("R6 reload from modulo", v, 8'hF0);
    check("R7 irq on reload", irq, 1);
    wait_to(e0 + 26); check("R7 irq one cycle only", irq, 0);
    wait_to(e0 + 41); rd(2'd1, v); check("R6 count continues after reload", v, 8'hF1);
    check("R7 irq low on plain step", irq, 0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_write_wins;
    int v, e0;
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h00); e0 = last_wr;
    wr(2'd3, 8'h05);
    wait_to(e0 + 8);
    wr(2'd1, 8'h55);
    rd(2'd1, v); check("R8 write beats step", v, 8'h55);
    wait_to(e0 + 25); rd(2'd1, v); check("R8 counting resumes", v, 8'h56);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00); e0 = last_wr;
    wr(2'd3, 8'h05);
    wait_to(e0 + 8);
    wr(2'd1, 8'h10);
    rd(2'd1, v); check("R8 write beats reload", v, 8'h10);
    check("R8 no irq when write wins", irq, 0);
    wait_to(e0 + 10); check("R8 no late irq", irq, 0);
    wr(2'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_divider();
    t_rate(2'b00, 1024);
    t_rate(2'b01, 16);
    t_rate(2'b10, 64);
    t_rate(2'b11, 256);
    t_disable();
    t_overflow();
    t_write_wins();
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < MAX_CYC) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule